// File: doc/BRIEF.md
# DVS Frequency-Voltage Handshake Sequencer

This block sits between a clock management unit and a supply regulator. It serves one to four scaled voltage domains. Each domain asks for a new frequency level with a valid/ready request: the level rides with `freq_valid` and the sequencer answers with a single-cycle `freq_ready` pulse. That pulse is the frequency acknowledge. For every domain, software keeps a small table that maps each level to an 8-bit voltage code. Levels 0 to 7 are running frequencies. Level 8, and any value above it, is the clock-stop level, and its entry may hold code 0, which turns the domain off.

On each request the sequencer looks up the target code and compares it with the code the domain was last given.

- **Higher code:** the sequencer sends the voltage command first and waits a programmable settle time. Only then does it acknowledge the frequency.
- **Lower code:** it acknowledges at once, then sends the command and lets the settle time run out before it takes the domain's next request.
- **Equal code:** it acknowledges and sends nothing.

All domains share one regulator command port, which is a valid/ready stream. The source holds `vcmd_valid`, `vcmd_dom` and `vcmd_code` steady until the cycle in which `vcmd_ready` is high; that cycle is the acceptance. The regulator may hold `vcmd_ready` low for as long as it likes. The settle timer only starts at acceptance. When several domains wait at once, the lowest domain index is served first.

The host reaches the tables, the settle count and the completion flags over an APB-style bus with no wait states. It is interrupted while any completion flag is set.

Top module: `dvs_seq_top`

## Requirements
- R1: After reset:
  - `freq_ready`, `vcmd_valid` and `irq` are low.
  - Every table entry reads 0.
  - The settle register reads 8.
  - Every domain's current code is 0.
- R2: Table access over the register bus:
  - The table entry for domain d, level l (l from 0 to 8) sits at byte address 16*d + l, with the code in bits 7:0.
  - Addresses with l above 8, or with d not below the domain count, ignore writes and read 0.
  - `pready` is always 1.
- R3: When the looked-up code is above the domain's current code, the command (domain, code) appears on the port in the cycle after the request is first seen. Exactly S+1 cycles lie between the acceptance cycle and the `freq_ready` cycle, where S is the settle register.
- R4: When the looked-up code is below the current code, `freq_ready` pulses in the cycle after the request is first seen, and the command follows in the next cycle. A new request from that domain is acknowledged no earlier than S+3 cycles after the acceptance cycle.
- R5: `freq_ready` for a domain is high for exactly one cycle per request. The requester holds `freq_valid` and its level until that cycle.
- R6: Request levels 8 to 15 all use the domain's clock-stop entry (address 16*d + 8), and that entry may hold code 0.
- R7: When the looked-up code equals the current code, `freq_ready` pulses in the cycle after the request is seen, and no command is issued.
- R8: While `vcmd_ready` is low, a presented command keeps `vcmd_valid`, `vcmd_dom` and `vcmd_code` unchanged. No acknowledge is given for that raise until S+1 cycles after acceptance.
- R9: When several domains present commands together, they are accepted one per cycle in increasing domain order. Each command carries its own domain number and code.
- R10: Register 0x41 holds one completion flag per domain in bit d, set when that domain's `freq_ready` pulses. Writing 1 to a bit clears it. `irq` is high while any flag is set.
- R11: Register 0x40 holds the 16-bit settle count S. It reads back what was written, and a value of 0 gives exactly one wait cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Register bus select |
| penable | input | 1 | Register bus access phase |
| pwrite | input | 1 | Register bus write strobe |
| paddr | input | 8 | Register byte address |
| pwdata | input | 16 | Register write data |
| prdata | output | 16 | Register read data |
| pready | output | 1 | Always 1 (no wait states) |
| irq | output | 1 | Any completion flag set |
| freq_valid | input | NUM_DOM | Frequency request per domain |
| freq_level | input | 4*NUM_DOM | Requested level, domain d at bits 4d+3:4d |
| freq_ready | output | NUM_DOM | Frequency acknowledge pulse per domain |
| vcmd_valid | output | 1 | Regulator command present |
| vcmd_dom | output | DOM_W | Domain of the command |
| vcmd_code | output | 8 | Voltage code of the command |
| vcmd_ready | input | 1 | Regulator accepts the command |

## Verification
The main function is driven with a vector table of requests whose targets are above, below and equal to the domain's current code. Each kind is told apart by where the acknowledge falls relative to the command handshake, or by whether a command appears at all. Clock-stop levels above 8 are mixed into the table to show that they reach the stop entry rather than some other entry. Directed runs cover three cases:
- back-pressure on the command port;
- a request re-issued straight after a lowering acknowledge, to show it is held until the settle time has run out;
- two domains raising at once, which separates priority order from per-domain codes.

A settle count of zero pins the edge of the timer.

// File: rtl/dvs_seq_pkg.sv
package dvs_seq_pkg;
  localparam int LVL_W    = 4;   // request level width
  localparam int NUM_LVL  = 9;   // eight running levels plus clock stop
  localparam int STOP_LVL = 8;   // index of the clock-stop entry
  localparam int CODE_W   = 8;   // voltage code width

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_WAIT = 2'd2,
    ST_ACK  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/dvs_regfile.sv
module dvs_regfile
  import dvs_seq_pkg::*;
#(
  parameter int NUM_DOM    = 2,
  parameter int SET_W      = 16,
  parameter int DEF_SETTLE = 8,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       psel,
  input  logic                       penable,
  input  logic                       pwrite,
  input  logic [ADDR_W-1:0]          paddr,
  input  logic [DATA_W-1:0]          pwdata,
  output logic [DATA_W-1:0]          prdata,
  input  logic [NUM_DOM*LVL_W-1:0]   lvl_i,
  output logic [NUM_DOM*CODE_W-1:0]  code_o,
  output logic [SET_W-1:0]           settle_o,
  input  logic [NUM_DOM-1:0]         done_set_i,
  output logic                       irq_o
);
  localparam logic [ADDR_W-1:0] SETTLE_ADDR = ADDR_W'(8'h40);
  localparam logic [ADDR_W-1:0] FLAG_ADDR   = ADDR_W'(8'h41);

  logic [CODE_W-1:0]  tbl_q [NUM_DOM][NUM_LVL];
  logic [SET_W-1:0]   settle_q;
  logic [NUM_DOM-1:0] flags_q;
  logic               wr_en;

  function automatic logic [ADDR_W-1:0] entry_addr(int d, int l);
    return ADDR_W'(d * 16 + l);
  endfunction

  assign wr_en = psel && penable && pwrite;

  // table storage: one register per (domain, level), decoded by full address
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < NUM_DOM; d++)
        for (int l = 0; l < NUM_LVL; l++)
          tbl_q[d][l] <= '0;
    end else if (wr_en) begin
      for (int d = 0; d < NUM_DOM; d++)
        for (int l = 0; l < NUM_LVL; l++)
          if (paddr == entry_addr(d, l))
            tbl_q[d][l] <= pwdata[CODE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_q <= SET_W'(DEF_SETTLE);
    end else if (wr_en && paddr == SETTLE_ADDR) begin
      settle_q <= pwdata[SET_W-1:0];
    end
  end

  // completion flags: set from sequencers, write-one-to-clear, set wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      if (wr_en && paddr == FLAG_ADDR)
        flags_q <= (flags_q & ~pwdata[NUM_DOM-1:0]) | done_set_i;
      else
        flags_q <= flags_q | done_set_i;
    end
  end

  always_comb begin
    prdata = '0;
    for (int d = 0; d < NUM_DOM; d++)
      for (int l = 0; l < NUM_LVL; l++)
        if (paddr == entry_addr(d, l))
          prdata[CODE_W-1:0] = tbl_q[d][l];
    if (paddr == SETTLE_ADDR) prdata[SET_W-1:0]   = settle_q;
    if (paddr == FLAG_ADDR)   prdata[NUM_DOM-1:0] = flags_q;
  end

  // lookup: levels at or above the stop index all use the stop entry
  always_comb begin
    logic [LVL_W-1:0] idx;
    code_o = '0;
    for (int d = 0; d < NUM_DOM; d++) begin
      idx = lvl_i[d*LVL_W +: LVL_W];
      if (idx > LVL_W'(STOP_LVL)) idx = LVL_W'(STOP_LVL);
      for (int l = 0; l < NUM_LVL; l++)
        if (idx == LVL_W'(l))
          code_o[d*CODE_W +: CODE_W] = tbl_q[d][l];
    end
  end

  assign settle_o = settle_q;
  assign irq_o    = |flags_q;

  // R10: a completion always raises the interrupt in the next cycle
  a_r10_flag_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (|done_set_i) |=> irq_o);
endmodule

// File: rtl/dvs_dom_seq.sv
module dvs_dom_seq
  import dvs_seq_pkg::*;
#(
  parameter int SET_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freq_valid_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [SET_W-1:0]  settle_i,
  output logic              freq_ready_o,
  output logic              cmd_valid_o,
  output logic [CODE_W-1:0] cmd_code_o,
  input  logic              cmd_grant_i
);
  seq_state_e        state_q;
  logic              up_q;
  logic              chg_q;
  logic [CODE_W-1:0] tgt_q;
  logic [CODE_W-1:0] cur_q;
  logic [SET_W-1:0]  cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      up_q    <= 1'b0;
      chg_q   <= 1'b0;
      tgt_q   <= '0;
      cur_q   <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (freq_valid_i) begin
          tgt_q <= code_i;
          up_q  <= code_i > cur_q;
          chg_q <= code_i != cur_q;
          state_q <= (code_i > cur_q) ? ST_CMD : ST_ACK;
        end
        ST_ACK:  state_q <= (up_q || !chg_q) ? ST_IDLE : ST_CMD;
        ST_CMD:  if (cmd_grant_i) begin
          cur_q   <= tgt_q;
          cnt_q   <= settle_i;
          state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (cnt_q == '0) state_q <= up_q ? ST_ACK : ST_IDLE;
          else             cnt_q   <= cnt_q - SET_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign freq_ready_o = (state_q == ST_ACK);
  assign cmd_valid_o  = (state_q == ST_CMD);
  assign cmd_code_o   = tgt_q;

  // R5: the acknowledge is a single-cycle pulse
  a_r5_ack_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    freq_ready_o |=> !freq_ready_o);

  // R3: a raising acknowledge only ever follows the settle wait
  a_r3_raise_ack_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_ready_o && up_q) |-> $past(state_q) == ST_WAIT);

  // R7: a command is only issued when it changes the domain's code
  a_r7_cmd_changes_code: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> cmd_code_o != cur_q);

  // R8: the timer does not start before the command is accepted
  a_r8_hold_until_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_grant_i) |=> cmd_valid_o && $stable(cmd_code_o));
endmodule

// File: rtl/dvs_cmd_arb.sv
module dvs_cmd_arb
  import dvs_seq_pkg::*;
#(
  parameter int NUM_DOM = 2,
  parameter int DOM_W   = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_DOM-1:0]        req_valid_i,
  input  logic [NUM_DOM*CODE_W-1:0] req_code_i,
  output logic [NUM_DOM-1:0]        grant_o,
  output logic                      vcmd_valid_o,
  output logic [DOM_W-1:0]          vcmd_dom_o,
  output logic [CODE_W-1:0]         vcmd_code_o,
  input  logic                      vcmd_ready_i
);
  logic             locked_q;
  logic [DOM_W-1:0] owner_q;
  logic [DOM_W-1:0] first;
  logic [DOM_W-1:0] pick;

  // fixed priority: lowest domain index wins
  always_comb begin
    first = '0;
    for (int i = NUM_DOM - 1; i >= 0; i--)
      if (req_valid_i[i]) first = DOM_W'(i);
  end

  // a stalled command keeps its owner so the payload stays put
  assign pick         = locked_q ? owner_q : first;
  assign vcmd_valid_o = |req_valid_i;
  assign vcmd_dom_o   = pick;

  always_comb begin
    vcmd_code_o = '0;
    grant_o     = '0;
    for (int i = 0; i < NUM_DOM; i++) begin
      if (pick == DOM_W'(i)) begin
        vcmd_code_o = req_code_i[i*CODE_W +: CODE_W];
        grant_o[i]  = vcmd_valid_o && vcmd_ready_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      owner_q  <= '0;
    end else begin
      locked_q <= vcmd_valid_o && !vcmd_ready_i;
      if (vcmd_valid_o && !vcmd_ready_i) owner_q <= pick;
    end
  end

  // R8: payload is frozen while the regulator back-pressures
  a_r8_payload_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (vcmd_valid_o && !vcmd_ready_i) |=>
      (vcmd_valid_o && $stable(vcmd_code_o) && $stable(vcmd_dom_o)));

  // R9: at most one domain is accepted per cycle
  a_r9_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));
endmodule

// File: rtl/dvs_seq_top.sv
module dvs_seq_top
  import dvs_seq_pkg::*;
#(
  parameter int NUM_DOM    = 2,
  parameter int SET_W      = 16,
  parameter int DEF_SETTLE = 8,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  localparam int DOM_W     = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     psel,
  input  logic                     penable,
  input  logic                     pwrite,
  input  logic [ADDR_W-1:0]        paddr,
  input  logic [DATA_W-1:0]        pwdata,
  output logic [DATA_W-1:0]        prdata,
  output logic                     pready,
  output logic                     irq,
  input  logic [NUM_DOM-1:0]       freq_valid,
  input  logic [NUM_DOM*LVL_W-1:0] freq_level,
  output logic [NUM_DOM-1:0]       freq_ready,
  output logic                     vcmd_valid,
  output logic [DOM_W-1:0]         vcmd_dom,
  output logic [CODE_W-1:0]        vcmd_code,
  input  logic                     vcmd_ready
);
  logic [NUM_DOM*CODE_W-1:0] look_code;
  logic [NUM_DOM*CODE_W-1:0] cmd_code;
  logic [NUM_DOM-1:0]        cmd_valid;
  logic [NUM_DOM-1:0]        cmd_grant;
  logic [SET_W-1:0]          settle;

  assign pready = 1'b1;

  dvs_regfile #(
    .NUM_DOM(NUM_DOM), .SET_W(SET_W), .DEF_SETTLE(DEF_SETTLE),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .lvl_i(freq_level), .code_o(look_code), .settle_o(settle),
    .done_set_i(freq_ready), .irq_o(irq)
  );

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    dvs_dom_seq #(.SET_W(SET_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .freq_valid_i(freq_valid[d]),
      .code_i(look_code[d*CODE_W +: CODE_W]),
      .settle_i(settle),
      .freq_ready_o(freq_ready[d]),
      .cmd_valid_o(cmd_valid[d]),
      .cmd_code_o(cmd_code[d*CODE_W +: CODE_W]),
      .cmd_grant_i(cmd_grant[d])
    );
  end

  dvs_cmd_arb #(.NUM_DOM(NUM_DOM), .DOM_W(DOM_W)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(cmd_valid), .req_code_i(cmd_code), .grant_o(cmd_grant),
    .vcmd_valid_o(vcmd_valid), .vcmd_dom_o(vcmd_dom),
    .vcmd_code_o(vcmd_code), .vcmd_ready_i(vcmd_ready)
  );
endmodule

// File: tb/test_dvs_seq_top.sv
module test_dvs_seq_top;
  localparam int ND = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [7:0]  paddr = '0;
  logic [15:0] pwdata = '0;
  logic [15:0] prdata;
  logic        pready, irq;
  logic [ND-1:0]   freq_valid = '0;
  logic [ND*4-1:0] freq_level = '0;
  logic [ND-1:0]   freq_ready;
  logic        vcmd_valid;
  logic [0:0]  vcmd_dom;
  logic [7:0]  vcmd_code;
  logic        vcmd_ready = 1'b1;

  always #10 clk = ~clk;  // 50 MHz

  dvs_seq_top #(.NUM_DOM(ND)) i_dvs_seq_top (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .irq(irq),
    .freq_valid(freq_valid), .freq_level(freq_level), .freq_ready(freq_ready),
    .vcmd_valid(vcmd_valid), .vcmd_dom(vcmd_dom), .vcmd_code(vcmd_code),
    .vcmd_ready(vcmd_ready)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] tbl_m [ND][9];
  logic [7:0] cur_m [ND];
  int settle_m;

  // {domain, level}: raise, raise, lower, equal, raise, raise, stop-lower, stop-lower, stop-equal, raise
  localparam logic [4:0] VECS [10] = '{5'h02, 5'h05, 5'h01, 5'h01, 5'h10,
                                       5'h17, 5'h1C, 5'h08, 5'h0F, 5'h13};

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apb_wr(int a, int v);
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = 8'(a); pwdata = 16'(v);
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(int a, output int v);
    @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = 8'(a);
    @(negedge clk); penable = 1; v = int'(prdata);
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic run_req(int d, int lvl);
    logic [7:0] exp;
    int kind, cyc, ack_c, cmd_c, ncmd, nack, code_g, dom_g;
    string tag;
    exp  = tbl_m[d][(lvl > 8) ? 8 : lvl];
    kind = (exp > cur_m[d]) ? 0 : ((exp < cur_m[d]) ? 1 : 2);
    tag  = (kind == 0) ? "R3 raise" : ((kind == 1) ? "R4 lower" : "R7 equal");
    if (lvl >= 8) tag = {"R6 ", tag};
    @(negedge clk); freq_valid[d] = 1'b1; freq_level[d*4 +: 4] = 4'(lvl);
    cyc = 0; ack_c = -1; cmd_c = -1; ncmd = 0; nack = 0; code_g = -1; dom_g = -1;
    while (cyc < 60 && (ack_c < 0 || (kind == 1 && cmd_c < 0))) begin
      @(negedge clk); cyc++;
      if (vcmd_valid && vcmd_ready) begin
        ncmd++; cmd_c = cyc; code_g = int'(vcmd_code); dom_g = int'(vcmd_dom);
      end
      if (freq_ready[d]) begin nack++; ack_c = cyc; freq_valid[d] = 1'b0; end
    end
    for (int k = 0; k < settle_m + 4; k++) begin
      @(negedge clk);
      if (vcmd_valid && vcmd_ready) ncmd++;
      if (freq_ready[d]) nack++;
    end
    if (kind == 0) begin
      chk({tag, " cmd cycle"}, cmd_c, 1);
      chk({tag, " cmd code"}, code_g, int'(exp));
      chk({tag, " cmd dom"}, dom_g, d);
      chk({tag, " ack cycle"}, ack_c, 1 + settle_m + 2);
      chk({tag, " cmd count"}, ncmd, 1);
    end else if (kind == 1) begin
      chk({tag, " ack cycle"}, ack_c, 1);
      chk({tag, " cmd cycle"}, cmd_c, 2);
      chk({tag, " cmd code"}, code_g, int'(exp));
      chk({tag, " cmd count"}, ncmd, 1);
    end else begin
      chk({tag, " ack cycle"}, ack_c, 1);
      chk({tag, " no command"}, ncmd, 0);
    end
    chk("R5 single ack pulse", nack, 1);
    cur_m[d] = exp;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int v, cyc, ack_c, ack1, ack2, cmd_c, bad;
    int h_dom [2], h_code [2], h_cyc [2], nh, a0, a1;
    for (int d = 0; d < ND; d++) begin
      cur_m[d] = '0;
      for (int l = 0; l < 8; l++) tbl_m[d][l] = 8'(16 * (l + 1) + d);
    end
    tbl_m[0][8] = 8'h00;
    tbl_m[1][8] = 8'h05;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 freq_ready", int'(freq_ready), 0);
    chk("R1 vcmd_valid", int'(vcmd_valid), 0);
    chk("R1 irq", int'(irq), 0);
    apb_rd(8'h40, v); chk("R1 settle default", v, 8);
    apb_rd(8'h13, v); chk("R1 table entry zero", v, 0);
    chk("R2 pready", int'(pready), 1);

    for (int d = 0; d < ND; d++)
      for (int l = 0; l < 9; l++) apb_wr(16 * d + l, int'(tbl_m[d][l]));
    apb_wr(8'h40, 3); settle_m = 3;
    apb_rd(8'h40, v); chk("R11 settle readback", v, 3);
    apb_rd(8'h18, v); chk("R2 readback d1 stop", v, 5);
    apb_rd(8'h04, v); chk("R2 readback d0 l4", v, 8'h50);

    // main vector table
    for (int i = 0; i < 10; i++) run_req(int'(VECS[i][4]), int'(VECS[i][3:0]));

    // R10 completion flags
    chk("R10 irq set", int'(irq), 1);
    apb_rd(8'h41, v); chk("R10 flags both", v, 3);
    apb_wr(8'h41, 1);
    apb_rd(8'h41, v); chk("R10 clear bit0", v, 2);
    chk("R10 irq still set", int'(irq), 1);
    apb_wr(8'h41, 2);
    apb_rd(8'h41, v); chk("R10 all clear", v, 0);
    chk("R10 irq low", int'(irq), 0);

    // R11 zero settle
    apb_wr(8'h40, 0); settle_m = 0;
    apb_rd(8'h40, v); chk("R11 settle zero readback", v, 0);
    run_req(0, 6);
    apb_wr(8'h40, 3); settle_m = 3;

    // R2 ignored addresses
    apb_wr(8'h09, 8'hAA);
    apb_rd(8'h09, v); chk("R2 level 9 reads 0", v, 0);
    apb_rd(8'h08, v); chk("R2 stop entry untouched", v, 0);
    apb_wr(8'h20, 8'h55);
    apb_rd(8'h20, v); chk("R2 domain 2 reads 0", v, 0);
    apb_rd(8'h00, v); chk("R2 d0 l0 untouched", v, 8'h10);

    // R8 back-pressure on dom1 raise to 0x71
    vcmd_ready = 1'b0;
    @(negedge clk); freq_valid[1] = 1'b1; freq_level[7:4] = 4'd6;
    bad = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (!vcmd_valid || vcmd_code != 8'h71 || vcmd_dom != 1'b1 || freq_ready[1]) bad++;
    end
    chk("R8 stalled command held", bad, 0);
    vcmd_ready = 1'b1;
    cyc = 0; ack_c = -1;
    while (cyc < 40 && ack_c < 0) begin
      @(negedge clk); cyc++;
      if (freq_ready[1]) begin ack_c = cyc; freq_valid[1] = 1'b0; end
    end
    chk("R8 ack after acceptance", ack_c, settle_m + 2);
    cur_m[1] = 8'h71;
    repeat (4) @(negedge clk);

    // R4 lower then immediate re-request (equal code)
    @(negedge clk); freq_valid[0] = 1'b1; freq_level[3:0] = 4'd3;
    cyc = 0; ack1 = -1; ack2 = -1; cmd_c = -1;
    while (cyc < 40 && ack2 < 0) begin
      @(negedge clk); cyc++;
      if (freq_ready[0]) begin
        if (ack1 < 0) ack1 = cyc; else ack2 = cyc;
        freq_valid[0] = 1'b0;
      end
      if (vcmd_valid && vcmd_ready) cmd_c = cyc;
      if (ack1 > 0 && cyc == ack1 + 1) freq_valid[0] = 1'b1;
    end
    chk("R4 lower ack first", ack1, 1);
    chk("R4 lower cmd", cmd_c, 2);
    chk("R4 next request held", ack2, cmd_c + settle_m + 3);
    cur_m[0] = 8'h40;
    repeat (4) @(negedge clk);

    // R9 two domains raise together
    @(negedge clk);
    freq_valid = 2'b11; freq_level = {4'd7, 4'd7};
    cyc = 0; nh = 0; a0 = -1; a1 = -1;
    while (cyc < 30 && (a0 < 0 || a1 < 0)) begin
      @(negedge clk); cyc++;
      if (vcmd_valid && vcmd_ready && nh < 2) begin
        h_dom[nh] = int'(vcmd_dom); h_code[nh] = int'(vcmd_code); h_cyc[nh] = cyc; nh++;
      end
      if (freq_ready[0]) begin a0 = cyc; freq_valid[0] = 1'b0; end
      if (freq_ready[1]) begin a1 = cyc; freq_valid[1] = 1'b0; end
    end
    chk("R9 handshakes", nh, 2);
    chk("R9 first dom", h_dom[0], 0);
    chk("R9 first code", h_code[0], 8'h80);
    chk("R9 first cycle", h_cyc[0], 1);
    chk("R9 second dom", h_dom[1], 1);
    chk("R9 second code", h_code[1], 8'h81);
    chk("R9 second cycle", h_cyc[1], 2);
    chk("R9 dom0 ack", a0, 1 + settle_m + 2);
    chk("R9 dom1 ack", a1, 2 + settle_m + 2);
    repeat (4) @(negedge clk);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule